// File: doc/BRIEF.md
# Multi-Context Receive Copy Controller

This block lets several virtual interfaces drain one shared receive packet store at the same time. Each interface posts a request word that names a host buffer address and a maximum length. The controller binds the oldest packet that no interface has claimed yet to that interface, or resumes the packet the interface already holds. It then asks an external copy engine to move the lesser of the requested length and the bytes still left in the packet, and it writes a completion word for that interface when the copy engine reports the move as done.

Requests are served one at a time, in the order they were posted. Between requests, an interface keeps its packet, its byte offset and the count of bytes left, so a large packet can be drained in pieces while other interfaces work on other packets. Packet storage is reclaimed strictly oldest-first. A packet that finishes early keeps its slot until every older packet has also finished. Checksum checking, the copy engine itself and the MAC sit outside the block: error flags arrive with each packet.

Top module: `rxv_copy_ctrl`

## Requirements
- R1: A request (`req_valid`) to an interface whose busy flag is clear sets that interface's busy bit (completion bit 31) and clears its complete bit (bit 30). A request to an interface that is still busy is discarded and raises `req_err` for one cycle.
- R2: Requests are served in the order they were accepted. While `rx_en` is low no new copy is started, and accepted requests wait.
- R3: An interface that holds no packet takes the oldest unclaimed packet. Slots are numbered in push order modulo SLOTS, starting at 0 after reset. If no unclaimed packet exists, the request waits without issuing a copy until one arrives.
- R4: Each copy pulses `dma_start` for one cycle. `dma_addr` is request bits ADDRW-1:0. `dma_len` is the lesser of request bits 59:40 and the bytes left in the packet. `dma_offset` is the number of bytes of that packet already copied.
- R5: On copy completion the interface's completion word has busy (bit 31) clear and complete (bit 30) set. Bits 25:23 hold the packet's error flags, with `pkt_flags[2:0]` mapped to bits 25:23 in that order. Bits 19:0 hold the copied length. Bits 47:32 hold the number of packets not yet fully copied. Bits 28:26 and 22:20 are zero.
- R6: If bytes remain after a copy, bit 29 (more) is set and the interface keeps its packet and offset for its next request. Another interface's requests never change that state.
- R7: `slots_used` counts occupied slots. A slot is freed only after its packet and every older packet have been fully copied.
- R8: Every copy completion pulses `irq_dma`. When no packet remains that is not fully copied, `irq_empty` pulses together with it.
- R9: A packet pushed while all SLOTS slots are occupied is dropped and is never handed to any interface.
- R10: After reset, `slots_used` is 0, every completion word reads 0, and `dma_start`, `irq_dma`, `irq_empty` and `req_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable; gates starting a new copy |
| req_valid | input | 1 | Request write strobe |
| req_ctx | input | $clog2(NCTX) | Interface index of the request |
| req_word | input | 64 | Request: length in bits 59:40, address in bits ADDRW-1:0 |
| req_err | output | 1 | One-cycle pulse when a request hits a busy interface |
| pkt_push | input | 1 | A packet enters the store |
| pkt_len | input | LENW | Length in bytes of the arriving packet (at least 1) |
| pkt_flags | input | 3 | Error flags {tcp, udp, ip} of the arriving packet |
| dma_start | output | 1 | One-cycle copy command |
| dma_addr | output | ADDRW | Host buffer address of the copy |
| dma_len | output | LENW | Byte count of the copy |
| dma_offset | output | LENW | Byte offset into the packet |
| dma_slot | output | $clog2(SLOTS) | Packet slot to copy from |
| dma_done | input | 1 | Copy engine finished the current copy |
| rd_ctx | input | $clog2(NCTX) | Interface whose completion word is shown |
| rd_done | output | 64 | Completion word of interface `rd_ctx` |
| irq_dma | output | 1 | Pulse on every copy completion |
| irq_empty | output | 1 | Pulse when no packet is left to copy |
| slots_used | output | $clog2(SLOTS)+1 | Occupied packet slots |

## Verification
The bench sweeps every pairing of packet length and request length from 1 to 6. A wrong minimum, offset update or more flag would show up as a bad length or offset on the copy command, or as a packet that ends one request early or late. One interface is made to finish a later packet while an earlier packet is still held partly copied by another interface. A design that frees space out of order would show `slots_used` falling too early, and one that shares context state would corrupt the resumed offset. Further cases are requests posted while receive is disabled, a duplicate request to a busy interface, a request with no packet available, and a push into a full store. These catch, in turn, service out of order, a busy request that is not dropped, a phantom copy, and a dropped packet that is later handed out.

// File: rtl/rxv_pkg.sv
package rxv_pkg;
   // request word layout
   localparam int REQ_LEN_LSB  = 40;
   // completion word layout
   localparam int CMP_CNT_LSB  = 32;
   localparam int CMP_CNT_W    = 16;
   localparam int CMP_BUSY     = 31;
   localparam int CMP_DONE     = 30;
   localparam int CMP_MORE     = 29;
   localparam int CMP_FLG_LSB  = 23;
   localparam int FLAG_W       = 3;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_FETCH,
      ST_ISSUE,
      ST_WAIT
   } rxv_state_e;
endpackage

// File: rtl/rxv_req_queue.sv
module rxv_req_queue #(
   parameter int DEPTH = 4,
   parameter int IDXW  = 2,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            push,
   input  logic [IDXW-1:0] push_idx,
   input  logic            pop,
   output logic [IDXW-1:0] head,
   output logic            empty
);
   logic [IDXW-1:0] mem [DEPTH];
   logic [AW-1:0]   rp, wp;
   logic [CW-1:0]   cnt;

   assign empty = (cnt == '0);
   assign head  = mem[rp];

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= push_idx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rp  <= '0;
         wp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
         if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
         cnt <= cnt + CW'(push) - CW'(pop);
      end
   end
endmodule

// File: rtl/rxv_slot_ring.sv
module rxv_slot_ring #(
   parameter int SLOTS = 4,
   parameter int LENW  = 20,
   parameter int FLGW  = 3,
   localparam int SW   = $clog2(SLOTS),
   localparam int PW   = SW + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            push,
   input  logic [LENW-1:0] push_len,
   input  logic [FLGW-1:0] push_flags,
   input  logic            take,
   input  logic            fin,
   input  logic [SW-1:0]   fin_slot,
   output logic            next_avail,
   output logic [SW-1:0]   next_slot,
   output logic [LENW-1:0] next_len,
   output logic [FLGW-1:0] next_flags,
   output logic [PW-1:0]   used,
   output logic [PW-1:0]   live,
   output logic [SW-1:0]   tail_slot,
   output logic [SLOTS-1:0] done_vec
);
   logic [PW-1:0]   wr_p, tl_p, nx_p;
   logic [LENW-1:0] len_q [SLOTS];
   logic [FLGW-1:0] flg_q [SLOTS];
   logic            accept, adv;

   assign used       = wr_p - tl_p;
   assign accept     = push && (used != PW'(SLOTS));
   assign tail_slot  = tl_p[SW-1:0];
   assign adv        = (used != '0) && done_vec[tail_slot];
   assign next_avail = (nx_p != wr_p);
   assign next_slot  = nx_p[SW-1:0];
   assign next_len   = len_q[next_slot];
   assign next_flags = flg_q[next_slot];

   always_ff @(posedge clk) begin
      if (accept) begin
         len_q[wr_p[SW-1:0]] <= push_len;
         flg_q[wr_p[SW-1:0]] <= push_flags;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_p <= '0;
         tl_p <= '0;
         nx_p <= '0;
         live <= '0;
      end else begin
         if (accept) wr_p <= wr_p + PW'(1);
         if (take)   nx_p <= nx_p + PW'(1);
         if (adv)    tl_p <= tl_p + PW'(1);
         live <= live + PW'(accept) - PW'(fin);
      end
   end

   // one finished marker per slot; cleared as the tail walks past it
   for (genvar i = 0; i < SLOTS; i++) begin : g_done
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            done_vec[i] <= 1'b0;
         else
            done_vec[i] <= (done_vec[i] && !(adv && tail_slot == SW'(i)))
                           || (fin && fin_slot == SW'(i));
      end
   end
endmodule

// File: rtl/rxv_copy_ctrl.sv
module rxv_copy_ctrl
   import rxv_pkg::*;
#(
   parameter int NCTX  = 4,
   parameter int SLOTS = 4,
   parameter int LENW  = 20,
   parameter int ADDRW = 40,
   localparam int IDXW = $clog2(NCTX),
   localparam int SW   = $clog2(SLOTS),
   localparam int PW   = SW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_en,
   input  logic             req_valid,
   input  logic [IDXW-1:0]  req_ctx,
   input  logic [63:0]      req_word,
   output logic             req_err,
   input  logic             pkt_push,
   input  logic [LENW-1:0]  pkt_len,
   input  logic [2:0]       pkt_flags,
   output logic             dma_start,
   output logic [ADDRW-1:0] dma_addr,
   output logic [LENW-1:0]  dma_len,
   output logic [LENW-1:0]  dma_offset,
   output logic [SW-1:0]    dma_slot,
   input  logic             dma_done,
   input  logic [IDXW-1:0]  rd_ctx,
   output logic [63:0]      rd_done,
   output logic             irq_dma,
   output logic             irq_empty,
   output logic [PW-1:0]    slots_used
);
   initial begin
      assert (NCTX >= 2) else $error("NCTX must be at least 2");
      assert (SLOTS >= 2 && (SLOTS & (SLOTS - 1)) == 0) else $error("SLOTS must be a power of two");
      assert (LENW >= 1 && LENW <= 20) else $error("LENW out of range");
      assert (ADDRW >= 1 && ADDRW <= REQ_LEN_LSB) else $error("ADDRW out of range");
   end

   // per-interface context
   logic [NCTX-1:0]   c_busy, c_has, c_cmpl, c_more;
   logic [SW-1:0]     c_slot [NCTX];
   logic [LENW-1:0]   c_off  [NCTX];
   logic [LENW-1:0]   c_rem  [NCTX];
   logic [LENW-1:0]   c_rlen [NCTX];
   logic [LENW-1:0]   c_clen [NCTX];
   logic [FLAG_W-1:0] c_flg  [NCTX];
   logic [FLAG_W-1:0] c_cflg [NCTX];
   logic [ADDRW-1:0]  c_addr [NCTX];

   rxv_state_e        st;
   logic [IDXW-1:0]   h;
   logic              q_empty, accept_req, take_w, fin_w, pop_w;
   logic [LENW-1:0]   cur_len, cut_w;
   logic              nx_avail;
   logic [SW-1:0]     nx_slot, ring_tail;
   logic [LENW-1:0]   nx_len;
   logic [FLAG_W-1:0] nx_flg;
   logic [PW-1:0]     live;
   logic [SLOTS-1:0]  ring_done;
   logic              req_unused;

   assign req_unused = &{1'b0, req_word};
   assign accept_req = req_valid && !c_busy[req_ctx];
   assign take_w     = (st == ST_FETCH) && !c_has[h] && nx_avail;
   assign pop_w      = (st == ST_WAIT) && dma_done;
   assign fin_w      = pop_w && (c_rem[h] == cur_len);
   assign cut_w      = (c_rlen[h] < c_rem[h]) ? c_rlen[h] : c_rem[h];

   rxv_req_queue #(.DEPTH(NCTX), .IDXW(IDXW)) u_queue (
      .clk(clk), .rst_n(rst_n), .push(accept_req), .push_idx(req_ctx),
      .pop(pop_w), .head(h), .empty(q_empty)
   );

   rxv_slot_ring #(.SLOTS(SLOTS), .LENW(LENW), .FLGW(FLAG_W)) u_ring (
      .clk(clk), .rst_n(rst_n), .push(pkt_push), .push_len(pkt_len),
      .push_flags(pkt_flags), .take(take_w), .fin(fin_w), .fin_slot(c_slot[h]),
      .next_avail(nx_avail), .next_slot(nx_slot), .next_len(nx_len),
      .next_flags(nx_flg), .used(slots_used), .live(live),
      .tail_slot(ring_tail), .done_vec(ring_done)
   );

   assign dma_start  = (st == ST_ISSUE);
   assign dma_addr   = c_addr[h];
   assign dma_len    = cut_w;
   assign dma_offset = c_off[h];
   assign dma_slot   = c_slot[h];

   // sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         cur_len   <= '0;
         irq_dma   <= 1'b0;
         irq_empty <= 1'b0;
         req_err   <= 1'b0;
      end else begin
         irq_dma   <= 1'b0;
         irq_empty <= 1'b0;
         req_err   <= req_valid && c_busy[req_ctx];
         unique case (st)
            ST_IDLE:  if (rx_en && !q_empty) st <= ST_FETCH;
            ST_FETCH: if (c_has[h] || nx_avail) st <= ST_ISSUE;
            ST_ISSUE: begin
               cur_len <= cut_w;
               st      <= ST_WAIT;
            end
            ST_WAIT: if (dma_done) begin
               st        <= ST_IDLE;
               irq_dma   <= 1'b1;
               irq_empty <= ((fin_w ? live - PW'(1) : live) == '0);
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // context file
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_busy <= '0;
         c_has  <= '0;
         c_cmpl <= '0;
         c_more <= '0;
         for (int i = 0; i < NCTX; i++) begin
            c_slot[i] <= '0;
            c_off[i]  <= '0;
            c_rem[i]  <= '0;
            c_rlen[i] <= '0;
            c_clen[i] <= '0;
            c_flg[i]  <= '0;
            c_cflg[i] <= '0;
            c_addr[i] <= '0;
         end
      end else begin
         if (accept_req) begin
            c_busy[req_ctx] <= 1'b1;
            c_cmpl[req_ctx] <= 1'b0;
            c_more[req_ctx] <= 1'b0;
            c_clen[req_ctx] <= '0;
            c_cflg[req_ctx] <= '0;
            c_addr[req_ctx] <= req_word[ADDRW-1:0];
            c_rlen[req_ctx] <= req_word[REQ_LEN_LSB +: LENW];
         end
         if (take_w) begin
            c_has[h]  <= 1'b1;
            c_slot[h] <= nx_slot;
            c_off[h]  <= '0;
            c_rem[h]  <= nx_len;
            c_flg[h]  <= nx_flg;
         end
         if (pop_w) begin
            c_busy[h] <= 1'b0;
            c_cmpl[h] <= 1'b1;
            c_clen[h] <= cur_len;
            c_cflg[h] <= c_flg[h];
            if (fin_w) begin
               c_has[h] <= 1'b0;
            end else begin
               c_more[h] <= 1'b1;
               c_rem[h]  <= c_rem[h] - cur_len;
               c_off[h]  <= c_off[h] + cur_len;
            end
         end
      end
   end

   // completion word view
   always_comb begin
      rd_done = '0;
      rd_done[CMP_CNT_LSB +: CMP_CNT_W] = CMP_CNT_W'(live);
      rd_done[CMP_BUSY]                 = c_busy[rd_ctx];
      rd_done[CMP_DONE]                 = c_cmpl[rd_ctx];
      rd_done[CMP_MORE]                 = c_more[rd_ctx];
      rd_done[CMP_FLG_LSB +: FLAG_W]    = c_cflg[rd_ctx];
      rd_done[LENW-1:0]                 = c_clen[rd_ctx];
   end
endmodule

// File: rtl/rxv_copy_ctrl_chk.sv
module rxv_copy_ctrl_chk #(
   parameter int NCTX  = 4,
   parameter int SLOTS = 4,
   localparam int IDXW = $clog2(NCTX),
   localparam int SW   = $clog2(SLOTS),
   localparam int PW   = SW + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic [IDXW-1:0]  req_ctx,
   input logic             req_err,
   input logic [NCTX-1:0]  busy_vec,
   input logic             dma_start,
   input logic             irq_dma,
   input logic             irq_empty,
   input logic [PW-1:0]    slots_used,
   input logic [SLOTS-1:0] ring_done,
   input logic [SW-1:0]    ring_tail
);
   // R1: a request to a busy interface is flagged next cycle
   p_busy_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && busy_vec[req_ctx]) |=> req_err);

   // R1: no error without a colliding request the cycle before
   p_err_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_err |-> $past(req_valid && busy_vec[req_ctx]));

   // R4: copy command is a single-cycle pulse
   p_single_issue_r4: assert property (@(posedge clk) disable iff (!rst_n)
      dma_start |=> !dma_start);

   // R7: occupancy only drops when the oldest slot had finished
   p_inorder_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (slots_used < $past(slots_used)) |-> $past(ring_done[ring_tail]));

   // R8: empty notice only accompanies a copy completion
   p_empty_with_dma_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_empty |-> irq_dma);

   // R9: occupancy never exceeds the slot count
   p_slot_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      slots_used <= PW'(SLOTS));
endmodule

bind rxv_copy_ctrl rxv_copy_ctrl_chk #(.NCTX(NCTX), .SLOTS(SLOTS)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ctx(req_ctx),
   .req_err(req_err), .busy_vec(c_busy), .dma_start(dma_start),
   .irq_dma(irq_dma), .irq_empty(irq_empty), .slots_used(slots_used),
   .ring_done(ring_done), .ring_tail(ring_tail)
);

// File: tb/rxv_copy_ctrl_bench.sv
module rxv_copy_ctrl_bench;
   localparam int NCTX  = 4;
   localparam int SLOTS = 4;
   localparam int LENW  = 20;
   localparam int ADDRW = 40;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic             rst_n, rx_en, req_valid, req_err, pkt_push, dma_start, dma_done;
   logic             irq_dma, irq_empty;
   logic [1:0]       req_ctx, rd_ctx, dma_slot;
   logic [63:0]      req_word, rd_done;
   logic [LENW-1:0]  pkt_len, dma_len, dma_offset;
   logic [2:0]       pkt_flags;
   logic [ADDRW-1:0] dma_addr;
   logic [2:0]       slots_used;

   rxv_copy_ctrl #(.NCTX(NCTX), .SLOTS(SLOTS), .LENW(LENW), .ADDRW(ADDRW)) u_rxv_copy_ctrl (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .req_valid(req_valid),
      .req_ctx(req_ctx), .req_word(req_word), .req_err(req_err),
      .pkt_push(pkt_push), .pkt_len(pkt_len), .pkt_flags(pkt_flags),
      .dma_start(dma_start), .dma_addr(dma_addr), .dma_len(dma_len),
      .dma_offset(dma_offset), .dma_slot(dma_slot), .dma_done(dma_done),
      .rd_ctx(rd_ctx), .rd_done(rd_done), .irq_dma(irq_dma),
      .irq_empty(irq_empty), .slots_used(slots_used)
   );

   int vecs = 0, miss = 0, nacc = 0;
   int n_dma = 0, n_emp = 0, n_err = 0, d_n = 0;
   bit finished = 0;
   longint d_addr [256];
   int     d_len  [256];
   int     d_off  [256];
   int     d_slot [256];

   task automatic chk(input string tag, input longint act, input longint exp);
      vecs++;
      if (act != exp) begin
         miss++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   // copy engine model: logs each command, answers two cycles later
   initial begin
      dma_done = 1'b0;
      forever begin
         @(negedge clk);
         if (dma_start) begin
            if (d_n < 256) begin
               d_addr[d_n] = longint'(dma_addr);
               d_len[d_n]  = int'(dma_len);
               d_off[d_n]  = int'(dma_offset);
               d_slot[d_n] = int'(dma_slot);
            end
            d_n++;
            @(negedge clk);
            @(negedge clk);
            dma_done = 1'b1;
            @(negedge clk);
            dma_done = 1'b0;
         end
      end
   end

   initial begin
      forever begin
         @(negedge clk);
         if (irq_dma)   n_dma++;
         if (irq_empty) n_emp++;
         if (req_err)   n_err++;
      end
   end

   task automatic push(input int len, input int flg, input bit counted);
      @(negedge clk);
      pkt_push = 1'b1; pkt_len = LENW'(len); pkt_flags = 3'(flg);
      @(negedge clk);
      pkt_push = 1'b0;
      if (counted) nacc++;
   endtask

   task automatic send(input int c, input int len, input longint addr);
      @(negedge clk);
      req_valid = 1'b1; req_ctx = 2'(c);
      req_word = (64'(len) << 40) | 64'(addr);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic rd(input int c, output logic [63:0] v);
      rd_ctx = 2'(c);
      #1;
      v = rd_done;
   endtask

   task automatic wait_free(input int c);
      logic [63:0] v;
      for (int i = 0; i < 300; i++) begin
         rd(c, v);
         if (!v[31]) break;
         @(negedge clk);
      end
      repeat (2) @(negedge clk);
      #1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         vecs++; miss++;
         $display("FAIL watchdog: got %0d expected %0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
         $finish;
      end
   end

   initial begin
      logic [63:0] v;
      int k, s, e0, m0, r0;
      rst_n = 1'b0; rx_en = 1'b0; req_valid = 1'b0; req_ctx = '0; req_word = '0;
      pkt_push = 1'b0; pkt_len = '0; pkt_flags = '0; rd_ctx = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: reset state
      chk("R10 slots_used", slots_used, 0);
      chk("R10 dma_start", dma_start, 0);
      chk("R10 irq", {irq_dma, irq_empty, req_err}, 0);
      for (int c = 0; c < NCTX; c++) begin
         rd(c, v);
         chk("R10 completion word", v, 0);
      end

      // R4 R5 R6 R8: sweep packet length against request length
      rx_en = 1'b1;
      for (int p = 1; p <= 6; p++) begin
         for (int r = 1; r <= 6; r++) begin
            int rem, slot, e1;
            rem = p; slot = nacc % SLOTS; e1 = n_emp;
            push(p, p % 8, 1);
            while (rem > 0) begin
               int c, kk;
               c = (r < rem) ? r : rem; kk = d_n;
               send(0, r, longint'(p * 256 + r));
               wait_free(0);
               chk("R4 one copy per request", d_n, kk + 1);
               chk("R4 copy length", d_len[kk], c);
               chk("R4 copy offset", d_off[kk], p - rem);
               chk("R4 copy address", d_addr[kk], p * 256 + r);
               chk("R3 slot in push order", d_slot[kk], slot);
               rd(0, v);
               chk("R5 complete bit", v[30], 1);
               chk("R1 busy cleared", v[31], 0);
               chk("R6 more bit", v[29], (rem > c) ? 1 : 0);
               chk("R5 length field", v[19:0], c);
               chk("R5 flag field", v[25:23], p % 8);
               chk("R5 reserved zero", {v[28:26], v[22:20]}, 0);
               rem -= c;
            end
            rd(0, v);
            chk("R5 packet count", v[47:32], 0);
            chk("R8 empty pulse", n_emp - e1, 1);
            chk("R7 slot freed", slots_used, 0);
         end
      end

      // R1 R2: queued while disabled, served in order, busy request dropped
      rx_en = 1'b0; k = d_n; s = nacc % SLOTS; e0 = n_emp; m0 = n_dma; r0 = n_err;
      push(5, 1, 1); push(5, 2, 1); push(5, 4, 1);
      send(1, 5, 64'h1000); send(2, 5, 64'h2000); send(3, 5, 64'h3000);
      rd(1, v);
      chk("R1 busy set", v[31], 1);
      chk("R1 complete cleared", v[30], 0);
      send(1, 9, 64'h9999);
      repeat (10) @(negedge clk);
      chk("R2 no copy while disabled", d_n, k);
      chk("R1 error pulse", n_err - r0, 1);
      rx_en = 1'b1;
      wait_free(1); wait_free(2); wait_free(3);
      chk("R2 order first", d_addr[k], 64'h1000);
      chk("R2 order second", d_addr[k+1], 64'h2000);
      chk("R2 order third", d_addr[k+2], 64'h3000);
      chk("R1 rejected request ignored", d_len[k], 5);
      chk("R3 slot first", d_slot[k], s);
      chk("R3 slot third", d_slot[k+2], (s + 2) % SLOTS);
      chk("R8 dma pulses", n_dma - m0, 3);
      chk("R8 single empty pulse", n_emp - e0, 1);

      // R3: no packet available, request waits
      k = d_n;
      send(0, 8, 64'h4000);
      repeat (20) @(negedge clk);
      chk("R3 no copy without packet", d_n, k);
      rd(0, v);
      chk("R3 still busy", v[31], 1);
      push(3, 2, 1);
      wait_free(0);
      chk("R3 copy after arrival", d_len[k], 3);
      rd(0, v);
      chk("R3 no more bit", v[29], 0);

      // R6 R7: partial packet held while a later packet finishes
      s = nacc % SLOTS;
      push(10, 1, 1); push(4, 4, 1);
      e0 = n_emp; k = d_n;
      send(1, 3, 64'h5000);
      wait_free(1);
      chk("R6 first slot", d_slot[k], s);
      chk("R6 partial length", d_len[k], 3);
      rd(1, v);
      chk("R6 more set", v[29], 1);
      chk("R5 count two", v[47:32], 2);
      send(2, 8, 64'h6000);
      wait_free(2);
      chk("R6 second slot", d_slot[k+1], (s + 1) % SLOTS);
      chk("R6 second length", d_len[k+1], 4);
      rd(2, v);
      chk("R6 second no more", v[29], 0);
      chk("R5 second flags", v[25:23], 4);
      chk("R7 later packet kept", slots_used, 2);
      chk("R8 no early empty", n_emp - e0, 0);
      send(1, 20, 64'h7000);
      wait_free(1);
      chk("R6 resume offset", d_off[k+2], 3);
      chk("R6 resume length", d_len[k+2], 7);
      chk("R6 resume slot", d_slot[k+2], s);
      rd(1, v);
      chk("R5 resume flags", v[25:23], 1);
      chk("R6 resume no more", v[29], 0);
      chk("R7 both freed", slots_used, 0);
      chk("R8 empty after last", n_emp - e0, 1);
      rd(2, v);
      chk("R6 other context untouched", v[19:0], 4);

      // R9: push into full store is dropped
      s = nacc % SLOTS;
      for (int i = 0; i < SLOTS; i++) push(2, 0, 1);
      push(7, 0, 0);
      repeat (2) @(negedge clk);
      chk("R9 occupancy full", slots_used, SLOTS);
      rd(0, v);
      chk("R9 packet count", v[47:32], SLOTS);
      for (int i = 0; i < SLOTS; i++) begin
         k = d_n;
         send(0, 9, 64'h8000 + 64'(i));
         wait_free(0);
         chk("R9 stored length", d_len[k], 2);
         chk("R9 slot order", d_slot[k], (s + i) % SLOTS);
      end
      k = d_n;
      send(0, 9, 64'h8800);
      repeat (20) @(negedge clk);
      chk("R9 dropped packet absent", d_n, k);
      push(1, 0, 1);
      wait_free(0);
      chk("R9 next packet length", d_len[k], 1);
      chk("R9 next packet slot", d_slot[k], s);
      chk("R7 drained", slots_used, 0);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
   end
endmodule